// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the software-facing half of a 51-source interrupt controller. It holds the per-source enable mask, the choice between the normal (IRQ) and the fast (FIQ) output, and the event polarity of the four highest sources. It combines these with the pending vector produced by a separate trigger-capture stage to drive two interrupt lines. The capture stage receives the fixed trigger configuration (level/edge sense, dual-edge, polarity) from this block. In return, the capture stage receives a one-cycle clear vector whenever software acknowledges edge-latched sources.

Software reaches the block through a simple 32-bit register bus with one valid strobe, a write flag, an address and write data. Read data is combinational in the cycle the read is presented. The active register window starts at offset 0x80, and everything below it is dead space. Each 51-bit quantity occupies a pair of words: the low word holds sources 31..0 and the word four bytes above it holds sources 50..32. The enable mask is changed through separate set and clear addresses, so no read-modify-write is needed.

Top module: `intc_regfile`

## Requirements
- R1: Accesses whose byte address is below 0x80, or whose address is not 4-byte aligned, read as 0 and leave every register unchanged.
- R2: With 0x80 subtracted from the address, bit 2 set selects the high word, which carries sources 50..32 in data bits 18..0. Data bits 31..19 of a high-word read are 0, and the same bits of a high-word write are discarded.
- R3: After reset, enable, select and the polarity override are 0 and both outputs are low. The sense vector reads 0x1F07FFF8FFFF, the dual-edge vector reads 0xF800070000, and the event vector reads 0x5F07FFF8FFFF.
- R4: Writing to the enable-set offset 0x20 ORs the 1 bits into the enable mask. Writing to the enable-clear offset 0x28 removes the 1 bits. Reading offset 0x20 returns the mask.
- R5: A write to the select offset 0x18 replaces only the addressed word of the select vector (1 = FIQ) and leaves the other word unchanged. Reading offset 0x18 returns the vector.
- R6: The event vector at offset 0x50 changes only through a high-word write, and only for sources 50..47 (data bits 18..15). A low-word write to it is ignored.
- R7: In the cycle of a write to offset 0x58, the output edge_clr carries the written bits masked with the inverse of sense. In every other cycle edge_clr is 0, and it never carries a level-sensed source.
- R8: Offset 0x00 reads raw & enable & ~select, offset 0x08 reads raw & enable & select, offset 0x10 reads raw, and offset 0x60 reads raw & ~sense.
- R9: Offsets 0x28, 0x38 and 0x58, the software trigger at 0x30, and unmapped offsets read 0. Writes to the status, sense, dual-edge and software offsets change nothing.
- R10: irq is the OR of raw & enable & ~select, and fiq is the OR of raw & enable & select, each registered one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| raw_pend | input | NSRC | Pending vector from the trigger-capture stage |
| edge_clr | output | NSRC | One-cycle clear vector to the trigger-capture stage |
| cfg_sense | output | NSRC | 1 = level-sensed source |
| cfg_dual | output | NSRC | 1 = source fires on both edges |
| cfg_event | output | NSRC | 1 = high level or rising edge |
| irq | output | 1 | Registered normal interrupt |
| fiq | output | 1 | Registered fast interrupt |

## Verification
The assertions check on every cycle the properties that hold at each access:
- legacy and misaligned reads return zero;
- high-word reads carry no bits above source 50;
- edge_clr is silent outside its write and never touches a level-sensed source;
- the non-writable event bits never move;
- a low-select write preserves the high half;
- an empty enable mask keeps both lines low in the next cycle.

The bench scenarios are needed to show the rest:
- the routing of each of the 51 sources to the right line with its one-cycle latency;
- set/clear accumulation over several patterns;
- the reset encodings;
- the status word contents;
- the fact that ignored writes leave the read-back values intact.

// File: rtl/intc_regfile.sv
module intc_regfile #(
  parameter int ADDR_W = 8,
  parameter int NSRC = 51,
  parameter int BASE = 128,
  parameter int EVT_LO = 47,
  parameter logic [NSRC-1:0] SENSE_RST = 51'h1F07FFF8FFFF,
  parameter logic [NSRC-1:0] DUAL_RST  = 51'h00F800070000,
  parameter logic [NSRC-1:0] EVENT_RST = 51'h5F07FFF8FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   raw_pend,
  output logic [NSRC-1:0]   edge_clr,
  output logic [NSRC-1:0]   cfg_sense,
  output logic [NSRC-1:0]   cfg_dual,
  output logic [NSRC-1:0]   cfg_event,
  output logic              irq,
  output logic              fiq
);
  localparam int HI_W = NSRC - 32;
  localparam logic [ADDR_W-1:0] K_IRQ  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] K_FIQ  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] K_RAW  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] K_SEL  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] K_ENS  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] K_ENC  = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] K_SNS  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] K_DUAL = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] K_EVT  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] K_ECLR = ADDR_W'(8'h58);
  localparam logic [ADDR_W-1:0] K_ESTS = ADDR_W'(8'h60);

  logic [NSRC-1:0]   en_q, sel_q, evt_q, wide, full;
  logic [ADDR_W-1:0] off, key;
  logic              hit, hi, wr, rd;

  assign off  = bus_addr - ADDR_W'(BASE);
  assign hit  = bus_valid && (bus_addr >= ADDR_W'(BASE)) && (off[1:0] == 2'b00);
  assign hi   = off[2];
  assign key  = {off[ADDR_W-1:3], 3'b000};
  assign wr   = hit && bus_write;
  assign rd   = hit && !bus_write;
  assign wide = hi ? {bus_wdata[HI_W-1:0], 32'h0} : {{HI_W{1'b0}}, bus_wdata};

  assign cfg_sense = SENSE_RST;
  assign cfg_dual  = DUAL_RST;
  assign cfg_event = evt_q;
  assign edge_clr  = (wr && key == K_ECLR) ? (wide & ~SENSE_RST) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
      evt_q <= EVENT_RST;
      irq   <= 1'b0;
      fiq   <= 1'b0;
    end else begin
      irq <= |(raw_pend & en_q & ~sel_q);
      fiq <= |(raw_pend & en_q & sel_q);
      if (wr) begin
        case (key)
          K_SEL: if (hi) sel_q[NSRC-1:32] <= bus_wdata[HI_W-1:0];
                 else    sel_q[31:0]      <= bus_wdata;
          K_ENS: en_q <= en_q | wide;
          K_ENC: en_q <= en_q & ~wide;
          K_EVT: if (hi) evt_q[NSRC-1:EVT_LO] <= wide[NSRC-1:EVT_LO];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    full = '0;
    if (rd) begin
      case (key)
        K_IRQ:  full = raw_pend & en_q & ~sel_q;
        K_FIQ:  full = raw_pend & en_q & sel_q;
        K_RAW:  full = raw_pend;
        K_SEL:  full = sel_q;
        K_ENS:  full = en_q;
        K_SNS:  full = SENSE_RST;
        K_DUAL: full = DUAL_RST;
        K_EVT:  full = evt_q;
        K_ESTS: full = raw_pend & ~SENSE_RST;
        default: full = '0;
      endcase
    end
    bus_rdata = hi ? 32'(full[NSRC-1:32]) : full[31:0];
  end
endmodule

module intc_regfile_chk #(
  parameter int ADDR_W = 8,
  parameter int NSRC = 51,
  parameter int BASE = 128,
  parameter int EVT_LO = 47
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NSRC-1:0]   edge_clr,
  input logic [NSRC-1:0]   cfg_sense,
  input logic [NSRC-1:0]   cfg_event,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   sel_q,
  input logic              irq,
  input logic              fiq
);
  localparam int HI_W = NSRC - 32;

  AST_LEGACY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr < ADDR_W'(BASE))) |-> bus_rdata == 32'h0); // R1
  AST_HIGH_WORD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[2]) |-> bus_rdata[31:HI_W] == '0); // R2
  AST_EDGE_CLR_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_clr & cfg_sense) == '0); // R7
  AST_EDGE_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |-> edge_clr == '0); // R7
  AST_EVENT_LOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg_event[EVT_LO-1:0])); // R6
  AST_SEL_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == ADDR_W'(BASE + 8'h18)) |=> $stable(sel_q[NSRC-1:32])); // R5
  AST_NO_ENABLE_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (!irq && !fiq)); // R10
endmodule

bind intc_regfile intc_regfile_chk #(
  .ADDR_W(ADDR_W), .NSRC(NSRC), .BASE(BASE), .EVT_LO(EVT_LO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .edge_clr(edge_clr),
  .cfg_sense(cfg_sense), .cfg_event(cfg_event), .en_q(en_q), .sel_q(sel_q),
  .irq(irq), .fiq(fiq)
);

// File: tb/intc_regfile_tb.sv
module intc_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [50:0] SENSE_X = 51'h1F07FFF8FFFF;
  localparam logic [50:0] DUAL_X  = 51'h00F800070000;
  localparam logic [50:0] EVENT_X = 51'h5F07FFF8FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [50:0] raw_pend = '0, edge_clr, cfg_sense, cfg_dual, cfg_event;
  logic irq, fiq;
  int checks = 0, failures = 0;
  logic [50:0] en_m = '0, sel_m = '0, evt_m = EVENT_X;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .raw_pend(raw_pend), .edge_clr(edge_clr), .cfg_sense(cfg_sense),
    .cfg_dual(cfg_dual), .cfg_event(cfg_event), .irq(irq), .fiq(fiq)
  );

  function automatic logic [31:0] word(input logic [50:0] v, input logic h);
    return h ? {13'h0, v[50:32]} : v[31:0];
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(rq, d, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    chk("R3 irq", irq, 0); chk("R3 fiq", fiq, 0);
    for (int h = 0; h < 2; h++) begin
      rd_chk("R3 sense", 8'hC0 + 8'(4*h), word(SENSE_X, h[0]));
      rd_chk("R3 dual",  8'hC8 + 8'(4*h), word(DUAL_X, h[0]));
      rd_chk("R3 event", 8'hD0 + 8'(4*h), word(EVENT_X, h[0]));
      rd_chk("R3 enable", 8'hA0 + 8'(4*h), 0);
      rd_chk("R3 select", 8'h98 + 8'(4*h), 0);
    end
    chk("R3 cfg_sense", cfg_sense, SENSE_X);
    chk("R3 cfg_dual", cfg_dual, DUAL_X);

    // R10 R5 R8 R4 per-source sweep
    for (int i = 0; i < 51; i++) begin
      logic h;
      logic [31:0] half;
      h = (i >= 32);
      raw_pend = 51'(1) << i;
      half = (i % 2 == 1) ? (32'h1 << (h ? i - 32 : i)) : 32'h0;
      wr(8'h98 + (h ? 8'h4 : 8'h0), half);
      if (h) sel_m[50:32] = half[18:0]; else sel_m[31:0] = half;
      rd_chk("R5 select lo", 8'h98, word(sel_m, 0));
      rd_chk("R5 select hi", 8'h9C, word(sel_m, 1));
      wr(8'hA0 + (h ? 8'h4 : 8'h0), h ? 32'h1 << (i - 32) : 32'h1 << i);
      en_m = en_m | (51'(1) << i);
      chk("R10 irq latency", irq, 0);
      chk("R10 fiq latency", fiq, 0);
      @(negedge clk);
      chk("R10 irq", irq, (i % 2 == 0));
      chk("R10 fiq", fiq, (i % 2 == 1));
      rd_chk("R8 irq status", 8'h80 + (h ? 8'h4 : 8'h0), word(raw_pend & en_m & ~sel_m, h));
      rd_chk("R8 fiq status", 8'h88 + (h ? 8'h4 : 8'h0), word(raw_pend & en_m & sel_m, h));
      wr(8'hA8 + (h ? 8'h4 : 8'h0), 32'hFFFF_FFFF);
      if (h) en_m[50:32] = '0; else en_m[31:0] = '0;
      rd_chk("R4 enable after clear", 8'hA0 + (h ? 8'h4 : 8'h0), 0);
    end

    // R4 R2 set/clear patterns
    wr(8'hA0, 32'hA5A5_A5A5);
    wr(8'hA4, 32'hFFFF_FFFF);
    wr(8'hA8, 32'h0F0F_0000);
    wr(8'hA0, 32'h0000_0100);
    rd_chk("R4 enable lo", 8'hA0, (32'hA5A5_A5A5 & ~32'h0F0F_0000) | 32'h100);
    rd_chk("R2 enable hi narrow", 8'hA4, 32'h0007_FFFF);
    wr(8'hAC, 32'hFFF8_0003);
    rd_chk("R2 R4 enable hi clear", 8'hA4, 32'h0007_FFFC);
    en_m = {19'h7FFFC, (32'hA5A5_A5A5 & ~32'h0F0F_0000) | 32'h100};

    // R6 event polarity
    wr(8'hD0, 32'h0);
    rd_chk("R6 event lo ignored", 8'hD0, word(EVENT_X, 0));
    wr(8'hD4, 32'h0);
    evt_m[50:47] = '0;
    rd_chk("R6 event hi clear", 8'hD4, word(evt_m, 1));
    wr(8'hD4, 32'hFFFF_FFFF);
    evt_m[50:47] = 4'hF;
    rd_chk("R6 event hi set", 8'hD4, word(evt_m, 1));
    chk("R6 cfg_event", cfg_event, evt_m);

    // R7 edge clear
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'hD8 + 8'(4*h); bus_wdata = 32'hFFFF_FFFF;
      #1 chk("R7 edge_clr pulse", edge_clr,
             (h == 1 ? {19'h7FFFF, 32'h0} : {19'h0, 32'hFFFF_FFFF}) & ~SENSE_X);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      #1 chk("R7 edge_clr idle", edge_clr, 0);
    end

    // R8 raw and edge status
    raw_pend = 51'h5_1234_F0F0_A5C3;
    for (int h = 0; h < 2; h++) begin
      rd_chk("R8 raw", 8'h90 + 8'(4*h), word(raw_pend, h[0]));
      rd_chk("R8 edge status", 8'hE0 + 8'(4*h), word(raw_pend & ~SENSE_X, h[0]));
    end

    // R9 write-only, software, unmapped, read-only
    rd_chk("R9 enable clear reads 0", 8'hA8, 0);
    rd_chk("R9 soft clear reads 0", 8'hB8, 0);
    rd_chk("R9 edge clear reads 0", 8'hD8, 0);
    rd_chk("R9 unmapped reads 0", 8'hE8, 0);
    wr(8'hB0, 32'hFFFF_FFFF);
    rd_chk("R9 soft reads 0", 8'hB0, 0);
    rd_chk("R9 soft write keeps enable", 8'hA0, word(en_m, 0));
    wr(8'hC0, 32'h0);
    rd_chk("R9 sense write ignored", 8'hC0, word(SENSE_X, 0));
    wr(8'hC8, 32'hFFFF_FFFF);
    rd_chk("R9 dual write ignored", 8'hC8, word(DUAL_X, 0));
    wr(8'h90, 32'h0);
    rd_chk("R9 raw write ignored", 8'h90, word(raw_pend, 0));

    // R1 legacy and misaligned
    rd_chk("R1 legacy read", 8'h10, 0);
    rd_chk("R1 misaligned read", 8'hA1, 0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'hA9, 32'hFFFF_FFFF);
    rd_chk("R1 legacy write ignored lo", 8'hA0, word(en_m, 0));
    rd_chk("R1 legacy write ignored hi", 8'hA4, word(en_m, 1));

    finish_run();
  end
endmodule